// File: doc/BRIEF.md
# Single-Bus Processor with Step-Sequenced Control

This block is a small processor core built around one shared internal bus. Its state lives in a program counter, a memory address register, a memory data register, an instruction register, four general registers, an ALU input latch and an ALU output latch. A hardwired controller runs a step counter through a one-hot step decoder. It combines the current step with the opcode held in the instruction register to raise the gate signals that choose which register drives the bus and which registers load from it. Every step is one clock cycle.

Instructions are 16-bit words. Bits 15:12 hold the opcode, bits 11:10 select a general register and bits 9:0 hold a word address or a jump offset. The core runs load, store, add-from-memory and relative jump instructions, plus a halt code. Memory is reached through a word-addressed request/complete port. A read or write strobe is raised and then held with a stable address and write data until the memory returns a one-cycle completion pulse. The memory may take any number of cycles, and it applies back-pressure by holding the completion low. During the instruction fetch, the program counter increment runs through the ALU while the fetch read is still outstanding.

Top module: `sbus_cpu`

## Requirements
- R1: Opcode in bits 15:12 selects the operation: 0 halt, 1 load register from [addr], 2 store register to [addr], 3 add [addr] into register, 4 relative jump. Bits 11:10 pick R0..R3 and bits 9:0 give the address.
- R2: Each instruction is fetched by a read at the current program counter. The counter becomes that address plus one before the instruction runs, so without jumps, fetches fall on consecutive addresses.
- R3: A strobe (mem_rd or mem_wr) rises in the cycle after the step that issues it and stays high until the cycle in which mem_done is high. No step that waits on memory advances while mem_done is low. With a memory that raises mem_done after L further cycles, every strobe is high for exactly L+1 cycles.
- R4: Load places the word read from the address into the selected register.
- R5: Store writes the selected register's value to the address as a single write request.
- R6: Add sets the selected register to its old value plus the memory word, modulo 2^16.
- R7: Jump loads the program counter with the incremented counter plus the 10-bit field sign-extended to 16 bits. Both forward and backward targets are possible.
- R8: An opcode from 5 to 15 ends right after its fetch, with no memory access and no register change.
- R9: Opcode 0 raises halted. halted stays high until reset, and no further memory request is made.
- R10: At most one source drives the internal bus in any cycle. mem_rd and mem_wr are never high together.
- R11: While rst_n is low, mem_rd, mem_wr and halted are low. The first request after reset is a read at address 0.
- R12: With a memory that completes in the first cycle of each request, a load takes 7 cycles from one fetch request to the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 10 | Word address of the current request |
| mem_wdata | output | 16 | Write data, valid while mem_wr is high |
| mem_rdata | input | 16 | Read data, sampled in the cycle mem_done is high |
| mem_rd | output | 1 | Read request, held until completion |
| mem_wr | output | 1 | Write request, held until completion |
| mem_done | input | 1 | One-cycle completion of the outstanding request |
| halted | output | 1 | High once a halt instruction has run |

## Verification
Some properties are checked on every cycle. Only one bus driver may be active. Read and write strobes must never overlap. An unanswered strobe must stay high. The step counter must freeze while a memory wait is unanswered, and it must restart at the first step after an end step. The halt state must stay set. The outcome of each instruction can only be shown by the directed programs, which inspect memory after the core halts. That covers loaded, stored and summed values, 16-bit wraparound, forward and backward jump targets and skipped unknown opcodes. The programs also record the order of fetch addresses, the per-request strobe length under several memory latencies, and the spacing between fetches.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  localparam int OPC_W  = 4;
  localparam int RSEL_W = 2;

  localparam logic [OPC_W-1:0] OP_HALT  = 4'd0;
  localparam logic [OPC_W-1:0] OP_LOAD  = 4'd1;
  localparam logic [OPC_W-1:0] OP_STORE = 4'd2;
  localparam logic [OPC_W-1:0] OP_ADD   = 4'd3;
  localparam logic [OPC_W-1:0] OP_JUMP  = 4'd4;

  // gate and action lines raised by the step decoder
  typedef struct packed {
    logic pc_out;
    logic z_out;
    logic mdr_out;
    logic rn_out;
    logic ira_out;
    logic pc_in;
    logic mar_in;
    logic mdr_in;
    logic ir_in;
    logic rn_in;
    logic y_in;
    logic z_in;
    logic y_clr;
    logic cin;
    logic rd;
    logic wr;
    logic wmfc;
    logic fin;
    logic halt;
  } ctl_t;
endpackage

// File: rtl/sbc_ctl.sv
module sbc_ctl
  import sbc_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opc,
  input  logic             mfc,
  output ctl_t             ctl,
  output logic             halted
);
  localparam int NSTEP = 1 << STEP_W;

  logic [STEP_W-1:0] step;
  logic [NSTEP-1:0]  t;

  // one-hot step decoder
  generate
    for (genvar g = 0; g < NSTEP; g++) begin : g_dec
      assign t[g] = (step == STEP_W'(g));
    end
  endgenerate

  always_comb begin
    ctl = '0;
    if (!halted) begin
      if (t[0]) begin
        ctl.pc_out = 1'b1; ctl.mar_in = 1'b1; ctl.rd = 1'b1;
        ctl.y_clr  = 1'b1; ctl.cin    = 1'b1; ctl.z_in = 1'b1;
      end else if (t[1]) begin
        ctl.z_out = 1'b1; ctl.pc_in = 1'b1; ctl.wmfc = 1'b1;
      end else if (t[2]) begin
        ctl.mdr_out = 1'b1; ctl.ir_in = 1'b1;
      end else begin
        case (opc)
          OP_HALT: ctl.halt = t[3];
          OP_LOAD: begin
            if (t[3]) begin ctl.ira_out = 1'b1; ctl.mar_in = 1'b1; ctl.rd = 1'b1; end
            if (t[4]) ctl.wmfc = 1'b1;
            if (t[5]) begin ctl.mdr_out = 1'b1; ctl.rn_in = 1'b1; end
            if (t[6]) ctl.fin = 1'b1;
          end
          OP_STORE: begin
            if (t[3]) begin ctl.ira_out = 1'b1; ctl.mar_in = 1'b1; end
            if (t[4]) begin ctl.rn_out = 1'b1; ctl.mdr_in = 1'b1; ctl.wr = 1'b1; end
            if (t[5]) ctl.wmfc = 1'b1;
            if (t[6]) ctl.fin = 1'b1;
          end
          OP_ADD: begin
            if (t[3]) begin ctl.ira_out = 1'b1; ctl.mar_in = 1'b1; ctl.rd = 1'b1; end
            if (t[4]) begin ctl.rn_out = 1'b1; ctl.y_in = 1'b1; ctl.wmfc = 1'b1; end
            if (t[5]) begin ctl.mdr_out = 1'b1; ctl.z_in = 1'b1; end
            if (t[6]) begin ctl.z_out = 1'b1; ctl.rn_in = 1'b1; end
            if (t[7]) ctl.fin = 1'b1;
          end
          OP_JUMP: begin
            if (t[3]) begin ctl.pc_out = 1'b1; ctl.y_in = 1'b1; end
            if (t[4]) begin ctl.ira_out = 1'b1; ctl.z_in = 1'b1; end
            if (t[5]) begin ctl.z_out = 1'b1; ctl.pc_in = 1'b1; end
            if (t[6]) ctl.fin = 1'b1;
          end
          default: ctl.fin = t[3];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step   <= '0;
      halted <= 1'b0;
    end else if (!halted) begin
      if (ctl.halt)                 halted <= 1'b1;
      else if (ctl.fin)             step   <= '0;
      else if (ctl.wmfc && !mfc)    step   <= step;
      else                          step   <= step + 1'b1;
    end
  end

  // R3
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.wmfc && !mfc) |=> $stable(step));
  // R12
  end_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.fin |=> (step == '0));
  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
endmodule

// File: rtl/sbc_mport.sv
module sbc_mport (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_req,
  input  logic wr_req,
  input  logic mem_done,
  output logic mem_rd,
  output logic mem_wr,
  output logic mfc,
  output logic mdr_ld
);
  logic rd_pend, wr_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend <= 1'b0;
      wr_pend <= 1'b0;
    end else begin
      if (rd_req)        rd_pend <= 1'b1;
      else if (mem_done) rd_pend <= 1'b0;
      if (wr_req)        wr_pend <= 1'b1;
      else if (mem_done) wr_pend <= 1'b0;
    end
  end

  assign mem_rd = rd_pend;
  assign mem_wr = wr_pend;
  assign mfc    = mem_done & (rd_pend | wr_pend);
  assign mdr_ld = mem_done & rd_pend;

  // R10
  rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_done) |=> mem_rd);
  // R3
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_done) |=> mem_wr);
endmodule

// File: rtl/sbc_dp.sv
module sbc_dp
  import sbc_pkg::*;
#(
  parameter int DW   = 16,
  parameter int AW   = 10,
  parameter int NREG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctl_t             ctl,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             mdr_ld,
  output logic [OPC_W-1:0] opc,
  output logic [AW-1:0]    mar,
  output logic [DW-1:0]    mdr
);
  localparam int SEL_W = $clog2(NREG);

  logic [DW-1:0]    pc, ir, y, z, bus, ira, rn, sum;
  logic [DW-1:0]    gpr [NREG];
  logic [SEL_W-1:0] rsel;
  logic             unused_ctl;

  assign unused_ctl = ^{ctl.rd, ctl.wr, ctl.wmfc, ctl.fin, ctl.halt};

  assign opc  = ir[DW-1 -: OPC_W];
  assign rsel = ir[DW-OPC_W-1 -: SEL_W];
  assign ira  = {{(DW-AW){ir[AW-1]}}, ir[AW-1:0]};
  assign rn   = gpr[rsel];

  // shared bus: AND-OR of gated sources
  assign bus = ({DW{ctl.pc_out}}  & pc)
             | ({DW{ctl.z_out}}   & z)
             | ({DW{ctl.mdr_out}} & mdr)
             | ({DW{ctl.rn_out}}  & rn)
             | ({DW{ctl.ira_out}} & ira);

  assign sum = (ctl.y_clr ? '0 : y) + bus + {{(DW-1){1'b0}}, ctl.cin};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc <= '0; ir <= '0; y <= '0; z <= '0; mar <= '0; mdr <= '0;
    end else begin
      if (ctl.pc_in)   pc  <= bus;
      if (ctl.ir_in)   ir  <= bus;
      if (ctl.y_in)    y   <= bus;
      if (ctl.z_in)    z   <= sum;
      if (ctl.mar_in)  mar <= bus[AW-1:0];
      if (ctl.mdr_in)  mdr <= bus;
      else if (mdr_ld) mdr <= mem_rdata;
    end
  end

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_gpr
      always_ff @(posedge clk) begin
        if (!rst_n)                                     gpr[g] <= '0;
        else if (ctl.rn_in && rsel == SEL_W'(g))        gpr[g] <= bus;
      end
    end
  endgenerate

  // R10
  bus_drv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl.pc_out, ctl.z_out, ctl.mdr_out, ctl.rn_out, ctl.ira_out}));
  // R10
  mdr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl.mdr_in && mdr_ld));
endmodule

// File: rtl/sbus_cpu.sv
module sbus_cpu
  import sbc_pkg::*;
#(
  parameter int DW     = 16,
  parameter int AW     = 10,
  parameter int NREG   = 4,
  parameter int STEP_W = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_rd,
  output logic          mem_wr,
  input  logic          mem_done,
  output logic          halted
);
  ctl_t             ctl;
  logic [OPC_W-1:0] opc;
  logic             mfc, mdr_ld;

  sbc_ctl #(.STEP_W(STEP_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .opc(opc), .mfc(mfc), .ctl(ctl), .halted(halted)
  );

  sbc_mport u_mport (
    .clk(clk), .rst_n(rst_n), .rd_req(ctl.rd), .wr_req(ctl.wr),
    .mem_done(mem_done), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mfc(mfc), .mdr_ld(mdr_ld)
  );

  sbc_dp #(.DW(DW), .AW(AW), .NREG(NREG)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .mem_rdata(mem_rdata),
    .mdr_ld(mdr_ld), .opc(opc), .mar(mem_addr), .mdr(mem_wdata)
  );

  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(halted) && halted) |-> !$rose(mem_rd) && !$rose(mem_wr));
endmodule

// File: tb/sim_sbus_cpu.sv
`timescale 1ns/1ps
module sim_sbus_cpu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        mem_rd, mem_wr;
  logic        mem_done = 1'b0;
  logic        halted;

  logic [15:0] mem [0:1023];
  int lat = 0, cnt = 0, cyc = 0;
  int nchk = 0, nfail = 0;
  int nreads = 0, nwrites = 0, both = 0, run = 0, max_run = 0;
  int rd_addr [64];
  int rd_cyc  [64];
  logic rd_prev = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  sbus_cpu u0 (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_done(mem_done), .halted(halted)
  );

  // memory model: answers L cycles after it first sees a request
  always @(negedge clk) begin
    mem_done = 1'b0;
    if (mem_rd && mem_wr) both++;
    if (mem_rd && !rd_prev && nreads < 64) begin
      rd_addr[nreads] = int'(mem_addr);
      rd_cyc[nreads]  = cyc;
      nreads++;
    end
    if (mem_rd) run++; else run = 0;
    if (run > max_run) max_run = run;
    rd_prev = mem_rd;
    if (rst_n && (mem_rd || mem_wr)) begin
      if (cnt >= lat) begin
        mem_done = 1'b1;
        cnt = 0;
        if (mem_rd) mem_rdata = mem[mem_addr];
        else begin
          mem[mem_addr] = mem_wdata;
          nwrites++;
        end
      end else cnt++;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic start(input int l);
    rst_n = 1'b0;
    lat = l; cnt = 0;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    nreads = 0; nwrites = 0; both = 0; run = 0; max_run = 0;
    rst_n = 1'b1;
  endtask

  task automatic run_to_halt();
    int n = 0;
    while (!halted && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(halted, "R9 halt reached", int'(halted), 1);
    check(both == 0, "R10 rd/wr overlap", both, 0);
  endtask

  task automatic t_reset();
    start(0);
    rst_n = 1'b0;
    @(negedge clk);
    // R11 idle outputs during reset
    check(!mem_rd && !mem_wr, "R11 strobes in reset", int'({mem_rd, mem_wr}), 0);
    check(!halted, "R11 halted in reset", int'(halted), 0);
    rst_n = 1'b1;
    mem[0] = 16'h0000;
    run_to_halt();
    check(rd_addr[0] == 0, "R11 first fetch address", rd_addr[0], 0);
  endtask

  task automatic t_load_store();
    start(0);
    mem[0] = 16'h1A01; mem[1] = 16'h2A00; mem[2] = 16'h0000;
    mem[10'h201] = 16'h0009;
    run_to_halt();
    // R4 R5 value moved through R2
    check(mem[10'h200] == 16'h0009, "R4 R5 stored load value", int'(mem[10'h200]), 9);
    check(nwrites == 1, "R5 single write", nwrites, 1);
    // R2 fetch order 0, data, 1, 2
    check(rd_addr[0] == 0 && rd_addr[2] == 1 && rd_addr[3] == 2, "R2 fetch order",
          rd_addr[2] * 16 + rd_addr[3], 16 * 1 + 2);
    check(rd_addr[1] == 'h201, "R1 address field", rd_addr[1], 'h201);
    // R12 fetch spacing for a load with zero-latency memory
    check(rd_cyc[2] - rd_cyc[0] == 7, "R12 load cycles", rd_cyc[2] - rd_cyc[0], 7);
  endtask

  task automatic t_add_slow();
    start(2);
    mem[0] = 16'h1A01; mem[1] = 16'h3A02; mem[2] = 16'h2A00; mem[3] = 16'h0000;
    mem[10'h201] = 16'h0009; mem[10'h202] = 16'h0006;
    run_to_halt();
    check(mem[10'h200] == 16'h000F, "R6 add result", int'(mem[10'h200]), 'hF);
    // R3 each strobe held L+1 cycles
    check(max_run == 3, "R3 strobe length lat2", max_run, 3);
  endtask

  task automatic t_add_wrap();
    start(1);
    mem[0] = 16'h1410; mem[1] = 16'h3411; mem[2] = 16'h2412; mem[3] = 16'h0000;
    mem[10'h010] = 16'hFFFF; mem[10'h011] = 16'h0002;
    run_to_halt();
    check(mem[10'h012] == 16'h0001, "R6 add wraps", int'(mem[10'h012]), 1);
    check(max_run == 2, "R3 strobe length lat1", max_run, 2);
  endtask

  task automatic t_jump();
    start(0);
    mem[0] = 16'h4003;                    // to 4
    mem[1] = 16'h1610; mem[2] = 16'h2611; mem[3] = 16'h0000;
    mem[4] = 16'h1613; mem[5] = 16'h2614;
    mem[6] = 16'h43FA;                    // back to 1
    mem[10'h210] = 16'h5A5A; mem[10'h213] = 16'hC3C3;
    run_to_halt();
    check(rd_addr[1] == 4, "R7 forward target", rd_addr[1], 4);
    check(rd_addr[5] == 1, "R7 backward target", rd_addr[5], 1);
    check(mem[10'h214] == 16'hC3C3 && mem[10'h211] == 16'h5A5A, "R7 both paths ran",
          int'(mem[10'h214]), 'hC3C3);
  endtask

  task automatic t_nop();
    start(1);
    mem[0] = 16'hF0AA; mem[1] = 16'h1E20; mem[2] = 16'h2E21; mem[3] = 16'h0000;
    mem[10'h0AA] = 16'h1234; mem[10'h220] = 16'h0777;
    run_to_halt();
    check(rd_addr[1] == 1, "R8 next fetch after unknown", rd_addr[1], 1);
    check(mem[10'h0AA] == 16'h1234 && nwrites == 1, "R8 no access", nwrites, 1);
    check(mem[10'h221] == 16'h0777, "R8 program continues", int'(mem[10'h221]), 'h777);
  endtask

  task automatic t_halt_idle();
    int r0;
    start(0);
    mem[0] = 16'h0000; mem[1] = 16'h1A01;
    run_to_halt();
    r0 = nreads;
    repeat (20) @(negedge clk);
    check(nreads == r0 && !mem_rd && !mem_wr, "R9 quiet after halt", nreads, r0);
    check(halted, "R9 halt sticky", int'(halted), 1);
  endtask

  initial begin
    #1000000;
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    t_reset();
    t_load_store();
    t_add_slow();
    t_add_wrap();
    t_jump();
    t_nop();
    t_halt_idle();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule